// File: doc/BRIEF.md
# Low-Power Wake Sequencer

This block follows the chip through its low-power states and brings it back to normal operation in a controlled order. The block has four states: run, deep-sleep, power-down and deep power-down. Software in run state asks for sleep with a one-cycle request that carries the target mode and a flag for the clock source in use. On entry the block records which interrupt lines may end the sleep. A line qualifies when it is enabled and its priority value is numerically below the current threshold.

When the block wakes, the resume delay depends on the mode and on the clock source. Deep-sleep keeps the flash and the internal RC oscillator powered, so the CPU resumes after a short or a long count. Power-down and deep power-down switch off the RC oscillator and the flash. On wake the block first powers them up again and waits for the oscillator-ready input. It then runs two counters in parallel: a short one that releases the CPU to run from SRAM, and a longer flash start-up timer that gates flash access. Deep power-down can only be entered when the RTC block co-signs the request. It is left only through an RTC alarm or through reset.

Top module: `lp_wake_seq`

## Requirements
- R1: Reset, sampled low at a clock edge, puts the block in run state from any state. In run state `pwr_state`=0, `osc_en`=1, `flash_pwr`=1, `flash_rdy`=1 and `cpu_resume`=0.
- R2: A `sleep_req` seen in run state while `flash_rdy`=1 is accepted at that edge. `sleep_mode` selects the mode: 0 deep-sleep, 1 power-down, 2 deep power-down. `pwr_state` then reads 1, 2 or 3 respectively until the CPU resumes. Mode code 3 is ignored.
- R3: The wake mask is captured at entry. Line i belongs to it when `irq_en[i]`=1 and `irq_prio[PRIO_W*i +: PRIO_W]` < `prio_thresh`. Lines outside the mask never wake the block, and changes to the enables or priorities after entry have no effect.
- R4: In deep-sleep with `clk_src_ext`=0, `cpu_resume` is high on the IRC_RESUME+2-th edge after the first edge that samples a masked line high (two synchronizer stages plus the count).
- R5: In deep-sleep with `clk_src_ext`=1, the same delay uses EXT_RESUME counts. Throughout deep-sleep, `flash_pwr` and `flash_rdy` stay 1.
- R6: In power-down and deep power-down, `osc_en`, `flash_pwr` and `flash_rdy` are 0 while asleep. A wake raises `osc_en` and `flash_pwr`, and the block then waits as long as `osc_ready` is low.
- R7: After `osc_ready` is sampled high in a power-down or deep power-down wake, `cpu_resume` rises IRC_RESUME edges later and `flash_rdy` rises FLASH_WAKE edges later. `pwr_state` returns to 0 together with `cpu_resume`.
- R8: Deep power-down is entered only when `rtc_req`=1 accompanies the request. While in it, interrupt lines are ignored and only `rtc_alarm` starts the wake.
- R9: Interrupt activity during a wake sequence neither restarts nor shortens the running counts.
- R10: A `sleep_req` that arrives before `flash_rdy` has risen again after a wake is ignored.
- R11: `cpu_resume` is a single-cycle pulse, issued once per wake and only as the block returns to run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to enter a low-power mode |
| sleep_mode | input | 2 | Target mode: 0 deep-sleep, 1 power-down, 2 deep power-down |
| clk_src_ext | input | 1 | 1 when the external oscillator clocks the chip at entry |
| rtc_req | input | 1 | RTC co-signature needed for deep power-down |
| irq_en | input | N_IRQ | Interrupt enables |
| irq_prio | input | N_IRQ*PRIO_W | Priority value per line, line i at bits PRIO_W*i upward |
| prio_thresh | input | PRIO_W | Lines with priority value below this may wake the block |
| irq_line | input | N_IRQ | Asynchronous interrupt lines |
| rtc_alarm | input | 1 | Asynchronous RTC alarm match |
| osc_ready | input | 1 | Internal RC oscillator has started |
| osc_en | output | 1 | Internal RC oscillator enable |
| flash_pwr | output | 1 | Flash power enable |
| flash_rdy | output | 1 | Flash access permitted |
| cpu_resume | output | 1 | One-cycle CPU resume strobe |
| pwr_state | output | 2 | 0 run, 1 deep-sleep, 2 power-down, 3 deep power-down |

## Verification
The hardest case to reach is the power-down wake, where two counters run at once. There, a new sleep request can arrive after the CPU has resumed but before flash is ready, and it must be rejected. The stimulus holds `osc_ready` low to park the block in its oscillator wait. It then releases `osc_ready` and, counting cycles from that moment, pulses an interrupt mid-count and issues a sleep request in the gap between the two expiries. A behavioural reference model compares every output on every cycle. Directed latency measurements check the exact edge of `cpu_resume` and of `flash_rdy` against the stated counts.

// File: rtl/lpw_pkg.sv
// Shared types for the low-power wake sequencer.
// Assumes: mode codes are fixed by the request interface (0,1,2 valid).
package lpw_pkg;

    typedef enum logic [1:0] {
        MODE_DSLEEP = 2'd0,
        MODE_PDOWN  = 2'd1,
        MODE_DPDOWN = 2'd2,
        MODE_RSVD   = 2'd3
    } lp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_OSC_WAIT = 2'd2,
        ST_RESUME   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/lpw_sync.sv
// Two-stage synchronizer for a vector of independent asynchronous lines.
// Assumes: each bit is a level that stays asserted long enough to be seen;
// no bus coherency between bits is needed.
module lpw_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture the lines in two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/lpw_wake_mask.sv
// Computes, per interrupt line, whether it is enabled and urgent enough
// to be serviced at once (priority value strictly below the threshold).
// Assumes: lower priority value means more urgent.
module lpw_wake_mask #(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 3
) (
    input  logic [N_IRQ-1:0]        irq_en,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]       prio_thresh,
    output logic [N_IRQ-1:0]        mask
);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        // Qualify one line by enable and priority.
        always_comb begin
            mask[i] = irq_en[i] && (irq_prio[i*PRIO_W +: PRIO_W] < prio_thresh);
        end
    end

endmodule

// File: rtl/lpw_timer.sv
// Single-shot down-counter. A start pulse loads a length; expire is high
// in the len-th cycle after the start edge, then the timer goes idle.
// Assumes: len >= 1; a start while busy reloads.
module lpw_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         busy,
    output logic         expire
);

    logic [W-1:0] cnt_q;
    logic         busy_q;

    // Load on start, count down while busy, go idle at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= len - W'(1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end

    assign busy   = busy_q;
    assign expire = busy_q && (cnt_q == '0);

endmodule

// File: rtl/lp_wake_seq.sv
// Low-power wake sequencer. Tracks run / deep-sleep / power-down /
// deep power-down, latches a wake mask on entry, and on wake sequences
// oscillator and flash power, the CPU resume strobe and the flash gate.
// Assumes: osc_ready is synchronous to clk; all delays are counted on clk,
// which stands in for the oscillator that runs during the wake.
module lp_wake_seq
    import lpw_pkg::*;
#(
    parameter int N_IRQ      = 8,
    parameter int PRIO_W     = 3,
    parameter int IRC_RESUME = 4,
    parameter int EXT_RESUME = 4096,
    parameter int FLASH_WAKE = 400
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_req,
    input  logic [1:0]              sleep_mode,
    input  logic                    clk_src_ext,
    input  logic                    rtc_req,
    input  logic [N_IRQ-1:0]        irq_en,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]       prio_thresh,
    input  logic [N_IRQ-1:0]        irq_line,
    input  logic                    rtc_alarm,
    input  logic                    osc_ready,
    output logic                    osc_en,
    output logic                    flash_pwr,
    output logic                    flash_rdy,
    output logic                    cpu_resume,
    output logic [1:0]              pwr_state
);

    localparam int RES_MAX = (EXT_RESUME > IRC_RESUME) ? EXT_RESUME : IRC_RESUME;
    localparam int CNT_MAX = (RES_MAX > FLASH_WAKE) ? RES_MAX : FLASH_WAKE;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state_q;
    lp_mode_e         mode_q;
    lp_mode_e         req_mode;
    logic             ext_q;
    logic [N_IRQ-1:0] mask_q;
    logic [N_IRQ-1:0] mask_now;
    logic [N_IRQ-1:0] irq_s;
    logic             rtc_s;
    logic             wake_hit;
    logic             accept;
    logic             res_start;
    logic [CNT_W-1:0] res_len;
    logic             res_busy;
    logic             res_exp;
    logic             fl_start;
    logic             fl_busy;
    logic             fl_exp;
    logic             flash_rdy_q;
    logic             resume_q;
    logic             deep_off;

    lpw_sync #(.W(N_IRQ + 1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rtc_alarm, irq_line}),
        .sync_out ({rtc_s, irq_s})
    );

    lpw_wake_mask #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_mask (
        .irq_en      (irq_en),
        .irq_prio    (irq_prio),
        .prio_thresh (prio_thresh),
        .mask        (mask_now)
    );

    // Decode the request and the wake condition for the current state.
    always_comb begin
        req_mode = lp_mode_e'(sleep_mode);
        accept   = (state_q == ST_RUN) && sleep_req && flash_rdy_q &&
                   ((req_mode == MODE_DSLEEP) || (req_mode == MODE_PDOWN) ||
                    ((req_mode == MODE_DPDOWN) && rtc_req));
        wake_hit = (mode_q == MODE_DPDOWN) ? rtc_s : |(irq_s & mask_q);
        fl_start = (state_q == ST_OSC_WAIT) && osc_ready;
        res_start = fl_start ||
                    ((state_q == ST_SLEEP) && wake_hit && (mode_q == MODE_DSLEEP));
        res_len  = ((state_q == ST_SLEEP) && ext_q) ? CNT_W'(EXT_RESUME)
                                                    : CNT_W'(IRC_RESUME);
        deep_off = (state_q == ST_SLEEP) && (mode_q != MODE_DSLEEP);
    end

    lpw_timer #(.W(CNT_W)) u_res_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (res_start),
        .len    (res_len),
        .busy   (res_busy),
        .expire (res_exp)
    );

    lpw_timer #(.W(CNT_W)) u_flash_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fl_start),
        .len    (CNT_W'(FLASH_WAKE)),
        .busy   (fl_busy),
        .expire (fl_exp)
    );

    // Sequence state: entry, wake detection, oscillator wait, resume count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mode_q  <= MODE_DSLEEP;
            ext_q   <= 1'b0;
            mask_q  <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (accept) begin
                        state_q <= ST_SLEEP;
                        mode_q  <= req_mode;
                        ext_q   <= clk_src_ext;
                        mask_q  <= mask_now;
                    end
                end
                ST_SLEEP: begin
                    if (wake_hit) begin
                        state_q <= (mode_q == MODE_DSLEEP) ? ST_RESUME : ST_OSC_WAIT;
                    end
                end
                ST_OSC_WAIT: begin
                    if (osc_ready) begin
                        state_q <= ST_RESUME;
                    end
                end
                ST_RESUME: begin
                    if (res_exp) begin
                        state_q <= ST_RUN;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Flash gate: drop on entry to a flash-off mode, raise at timer expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_rdy_q <= 1'b1;
        end else if (accept && (req_mode != MODE_DSLEEP)) begin
            flash_rdy_q <= 1'b0;
        end else if (fl_exp) begin
            flash_rdy_q <= 1'b1;
        end
    end

    // Resume strobe: one cycle as the resume count completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q <= 1'b0;
        end else begin
            resume_q <= (state_q == ST_RESUME) && res_exp;
        end
    end

    assign osc_en     = !deep_off;
    assign flash_pwr  = !deep_off;
    assign flash_rdy  = flash_rdy_q;
    assign cpu_resume = resume_q;
    assign pwr_state  = (state_q == ST_RUN) ? 2'd0 : (2'(mode_q) + 2'd1);

endmodule

// File: rtl/lp_wake_seq_chk.sv
// Assertion checker for lp_wake_seq, attached by bind below.
// Assumes: observes top-level ports only.
module lp_wake_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic [1:0] sleep_mode,
    input logic       rtc_req,
    input logic       osc_en,
    input logic       flash_pwr,
    input logic       flash_rdy,
    input logic       cpu_resume,
    input logic [1:0] pwr_state
);

    // R1: a reset edge leaves the block in run state with power on.
    p_reset_run_r1: assert property (@(posedge clk)
        !rst_n |=> (pwr_state == 2'd0 && osc_en && flash_pwr && flash_rdy && !cpu_resume));

    // R2: reserved mode code is never accepted.
    p_rsvd_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req && sleep_mode == 2'd3) |=> pwr_state == 2'd0);

    // R8: deep power-down needs the RTC co-signature.
    p_dpd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req && sleep_mode == 2'd2 && !rtc_req) |=> pwr_state == 2'd0);

    // R6: flash cannot be ready while unpowered.
    p_flash_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rdy |-> flash_pwr);

    // R5: deep-sleep keeps flash usable.
    p_ds_flash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1) |-> (flash_rdy && flash_pwr));

    // R7: the resume strobe coincides with the return to run state.
    p_resume_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resume |-> pwr_state == 2'd0);

    // R11: the resume strobe lasts one cycle.
    p_resume_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resume |=> !cpu_resume);

endmodule

bind lp_wake_seq lp_wake_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .sleep_mode (sleep_mode),
    .rtc_req    (rtc_req),
    .osc_en     (osc_en),
    .flash_pwr  (flash_pwr),
    .flash_rdy  (flash_rdy),
    .cpu_resume (cpu_resume),
    .pwr_state  (pwr_state)
);

// File: tb/lp_wake_seq_bench.sv
// Bench for lp_wake_seq: behavioural reference model compared every cycle,
// plus directed latency and corner-case checks.
module lp_wake_seq_bench;

    localparam int N   = 8;
    localparam int PW  = 3;
    localparam int IRC = 4;
    localparam int EXT = 4096;
    localparam int FL  = 400;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            sleep_req;
    logic [1:0]      sleep_mode;
    logic            clk_src_ext;
    logic            rtc_req;
    logic [N-1:0]    irq_en;
    logic [N*PW-1:0] irq_prio;
    logic [PW-1:0]   prio_thresh;
    logic [N-1:0]    irq_line;
    logic            rtc_alarm;
    logic            osc_ready;
    logic            osc_en;
    logic            flash_pwr;
    logic            flash_rdy;
    logic            cpu_resume;
    logic [1:0]      pwr_state;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lp_wake_seq #(
        .N_IRQ(N), .PRIO_W(PW), .IRC_RESUME(IRC), .EXT_RESUME(EXT), .FLASH_WAKE(FL)
    ) u_lp_wake_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .clk_src_ext(clk_src_ext), .rtc_req(rtc_req), .irq_en(irq_en),
        .irq_prio(irq_prio), .prio_thresh(prio_thresh), .irq_line(irq_line),
        .rtc_alarm(rtc_alarm), .osc_ready(osc_ready), .osc_en(osc_en),
        .flash_pwr(flash_pwr), .flash_rdy(flash_rdy), .cpu_resume(cpu_resume),
        .pwr_state(pwr_state)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    int           m_phase;   // 0 run, 1 asleep, 2 oscillator wait, 3 counting
    int           m_mode;
    bit           m_ext;
    bit [N-1:0]   m_mask;
    int           m_rcnt;
    int           m_fcnt;
    bit           m_frdy;
    bit           m_res;
    logic [N:0]   pipe[$];

    always @(posedge clk) begin
        logic [N:0] oldest;
        bit hit;
        bit frdy_old;
        if (!rst_n) begin
            m_phase = 0; m_mode = 0; m_ext = 0; m_mask = '0;
            m_rcnt = 0; m_fcnt = 0; m_frdy = 1; m_res = 0;
            pipe = {};
            pipe.push_back('0);
            pipe.push_back('0);
        end else begin
            oldest   = pipe.pop_front();
            hit      = (m_mode == 2) ? oldest[N] : |(oldest[N-1:0] & m_mask);
            frdy_old = m_frdy;
            m_res    = 0;
            if (m_fcnt > 0) begin
                m_fcnt--;
                if (m_fcnt == 0) m_frdy = 1;
            end
            case (m_phase)
                0: if (sleep_req && frdy_old &&
                       (sleep_mode == 0 || sleep_mode == 1 || (sleep_mode == 2 && rtc_req))) begin
                       m_phase = 1;
                       m_mode  = int'(sleep_mode);
                       m_ext   = clk_src_ext;
                       for (int i = 0; i < N; i++)
                           m_mask[i] = irq_en[i] && (irq_prio[i*PW +: PW] < prio_thresh);
                       if (sleep_mode != 0) m_frdy = 0;
                   end
                1: if (hit) begin
                       if (m_mode == 0) begin
                           m_phase = 3;
                           m_rcnt  = m_ext ? EXT : IRC;
                       end else begin
                           m_phase = 2;
                       end
                   end
                2: if (osc_ready) begin
                       m_phase = 3; m_rcnt = IRC; m_fcnt = FL;
                   end
                default: begin
                    m_rcnt--;
                    if (m_rcnt == 0) begin
                        m_phase = 0; m_res = 1;
                    end
                end
            endcase
            pipe.push_back({rtc_alarm, irq_line});
        end
    end

    // Compare every output to the model away from the active edge.
    always @(negedge clk) begin
        int  e_ps;
        bit  e_off;
        e_ps  = (m_phase == 0) ? 0 : m_mode + 1;
        e_off = (m_phase == 1) && (m_mode != 0);
        chk(pwr_state == 2'(e_ps), "R2 model pwr_state", int'(pwr_state), e_ps);
        chk(osc_en == !e_off, "R6 model osc_en", int'(osc_en), int'(!e_off));
        chk(flash_pwr == !e_off, "R6 model flash_pwr", int'(flash_pwr), int'(!e_off));
        chk(flash_rdy == m_frdy, "R7 model flash_rdy", int'(flash_rdy), int'(m_frdy));
        chk(cpu_resume == m_res, "R11 model cpu_resume", int'(cpu_resume), int'(m_res));
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        report();
    end

    // ---------------- directed helpers ----------------
    task automatic go_sleep(input int mode, input bit ext, input bit rtc);
        @(negedge clk);
        sleep_req = 1; sleep_mode = 2'(mode); clk_src_ext = ext; rtc_req = rtc;
        @(negedge clk);
        sleep_req = 0; rtc_req = 0;
    endtask

    // Count negedges from now until cpu_resume is seen.
    task automatic wait_resume(output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_resume && lat < 6000);
    endtask

    task automatic wait_flash();
        int n = 0;
        while (!flash_rdy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int lat;
        int r_c;
        int f_c;
        rst_n = 0; sleep_req = 0; sleep_mode = 0; clk_src_ext = 0; rtc_req = 0;
        irq_en = '1; prio_thresh = 3'd4; irq_line = '0; rtc_alarm = 0; osc_ready = 1;
        for (int i = 0; i < N; i++) irq_prio[i*PW +: PW] = PW'(i);

        repeat (3) @(negedge clk);
        chk(pwr_state == 0 && osc_en && flash_pwr && flash_rdy && !cpu_resume,
            "R1 reset state", int'(pwr_state), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 / R4: deep-sleep on RC, masked line 0 wakes.
        go_sleep(0, 0, 0);
        chk(pwr_state == 1, "R2 deep-sleep entry", int'(pwr_state), 1);
        irq_line[0] = 1;
        wait_resume(lat);
        irq_line[0] = 0;
        chk(lat == IRC + 3, "R4 deep-sleep RC latency", lat, IRC + 3);
        @(negedge clk);
        chk(!cpu_resume, "R11 single pulse", int'(cpu_resume), 0);

        // R5: deep-sleep on external oscillator.
        go_sleep(0, 1, 0);
        irq_line[3] = 1;
        wait_resume(lat);
        irq_line[3] = 0;
        chk(lat == EXT + 3, "R5 deep-sleep ext latency", lat, EXT + 3);
        chk(flash_rdy == 1, "R5 flash ready kept", int'(flash_rdy), 1);

        // R3: unmasked line 5 (priority 5 >= 4) and post-entry enable change.
        irq_en = 8'hFE;
        go_sleep(0, 0, 0);
        irq_en = 8'hFF;
        irq_line[5] = 1; irq_line[0] = 1;
        repeat (40) @(negedge clk);
        chk(pwr_state == 1, "R3 unmasked lines ignored", int'(pwr_state), 1);
        irq_line[5] = 0; irq_line[0] = 0;
        @(negedge clk);
        irq_line[2] = 1;
        wait_resume(lat);
        irq_line[2] = 0;
        chk(lat == IRC + 3, "R3 masked line wakes", lat, IRC + 3);

        // R6 / R7 / R9 / R10: power-down wake with split CPU and flash release.
        osc_ready = 0;
        go_sleep(1, 0, 0);
        chk(!osc_en && !flash_pwr && !flash_rdy && pwr_state == 2,
            "R6 power-down off", int'(osc_en), 0);
        irq_line[1] = 1;
        repeat (4) @(negedge clk);
        irq_line[1] = 0;
        chk(osc_en && flash_pwr, "R6 power restored on wake", int'(osc_en), 1);
        repeat (20) @(negedge clk);
        chk(pwr_state == 2 && !cpu_resume, "R6 waits for oscillator", int'(pwr_state), 2);
        osc_ready = 1;
        r_c = 0; f_c = 0;
        for (int c = 1; c <= FL + 3; c++) begin
            @(negedge clk);
            if (cpu_resume && r_c == 0) r_c = c;
            if (flash_rdy && f_c == 0) f_c = c;
            if (c == 2) irq_line[0] = 1;
            if (c == 3) irq_line[0] = 0;
            if (c == IRC + 3) begin sleep_req = 1; sleep_mode = 0; end
            if (c == IRC + 4) sleep_req = 0;
            if (c == IRC + 5)
                chk(pwr_state == 0, "R10 request before flash ready ignored", int'(pwr_state), 0);
        end
        chk(r_c == IRC + 1, "R9 resume count not restarted", r_c, IRC + 1);
        chk(f_c == FL + 1, "R7 flash ready latency", f_c, FL + 1);
        chk(f_c > r_c, "R7 flash after CPU", f_c, r_c);

        // R2 / R8: deep power-down gating and wake source.
        go_sleep(2, 0, 0);
        chk(pwr_state == 0, "R8 no rtc_req rejected", int'(pwr_state), 0);
        go_sleep(3, 0, 0);
        chk(pwr_state == 0, "R2 reserved mode ignored", int'(pwr_state), 0);
        osc_ready = 0;
        go_sleep(2, 0, 1);
        chk(pwr_state == 3, "R8 deep power-down entry", int'(pwr_state), 3);
        irq_line[0] = 1;
        repeat (30) @(negedge clk);
        irq_line[0] = 0;
        chk(pwr_state == 3 && !osc_en, "R8 interrupts ignored", int'(osc_en), 0);
        rtc_alarm = 1;
        repeat (4) @(negedge clk);
        rtc_alarm = 0;
        chk(osc_en == 1, "R8 alarm wakes", int'(osc_en), 1);
        osc_ready = 1;
        wait_resume(lat);
        chk(lat == IRC + 1, "R8 resume after alarm", lat, IRC + 1);
        wait_flash();

        // R1: reset while asleep in power-down.
        go_sleep(1, 0, 0);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(pwr_state == 0 && osc_en && flash_pwr && flash_rdy,
            "R1 reset from sleep", int'(pwr_state), 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        report();
    end

endmodule